// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer

This block is a small, fully associative translation cache that turns a 64-bit effective address into a 42-bit real address. Each entry holds its own page size, so one array can mix 4 KB, 64 KB, 1 MB, 16 MB and 1 GB mappings. The lookup key is wider than the effective address alone. It also carries a guest-state bit, an address-space bit, an 8-bit partition identifier and a 14-bit process identifier. The address-space bit is taken from the instruction-space bit on a fetch and from the data-space bit otherwise.

The lookup is purely combinational. Every valid entry compares the key, but only over the effective-page bits that lie above its own page boundary. When exactly one entry matches, the real address is that entry's page frame above the boundary, joined with the effective address below it. Entries are loaded through a single-cycle write port. The port refuses a write whose size code is not one of the supported ones, or whose page frame has nonzero bits below the page boundary, and it reports each refusal with a one-cycle error pulse. A synchronous reset or an invalidate-all strobe empties the array in one cycle.

Top module: `mmu_xlate_cam`

## Requirements
- R1: An entry matches only if its stored guest-state bit, address-space bit, partition ID and process ID all equal the lookup's, and its effective page number equals the lookup address above the entry's page boundary.
- R2: The lookup address-space bit is `lk_is` when `lk_ifetch` is 1 and `lk_ds` when `lk_ifetch` is 0.
- R3: The 4-bit size codes are 0001 = 4 KB, 0011 = 64 KB, 0101 = 1 MB, 0111 = 16 MB and 1010 = 1 GB. The page offset is the low 10+2*code address bits, and effective-address bits below that boundary play no part in matching.
- R4: On a single hit, `lk_ra` bits 41 down to the page boundary come from the entry's frame (`wr_rpn` holds real-address bits 41..12), and the bits below the boundary come from `lk_ea`.
- R5: A write with any other size code leaves the addressed entry unchanged and raises `wr_err` for exactly the cycle after the write.
- R6: A write whose frame has a nonzero bit below the page boundary (frame bits [2*code-3:0] for sizes above 4 KB) is refused in the same way. A 4 KB frame has no such constraint.
- R7: When no entry matches, `lk_hit` is 0 and `lk_ra` is 0.
- R8: When two or more entries match, `lk_multi` is 1, `lk_hit` is 0 and `lk_ra` is 0. With exactly one match, `lk_multi` is 0.
- R9: After a synchronous reset, no entry is valid and `wr_err` is 0.
- R10: `inval_all` empties every entry by the next cycle. It takes priority over a write in the same cycle, which is then dropped without an error pulse.
- R11: An accepted write to an index replaces that entry's previous mapping entirely.
- R12: A lookup in the same cycle as a write sees the array as it was before the write. The new entry is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Invalidate every entry |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_gs | input | 1 | Guest-state bit of the new entry |
| wr_as | input | 1 | Address-space bit of the new entry |
| wr_lpid | input | 8 | Partition ID of the new entry |
| wr_pid | input | 14 | Process ID of the new entry |
| wr_epn | input | 52 | Effective page number (address bits 63..12) |
| wr_size | input | 4 | Page size code |
| wr_rpn | input | 30 | Real page frame (real-address bits 41..12) |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| lk_gs | input | 1 | Lookup guest-state bit |
| lk_ds | input | 1 | Data-space state bit |
| lk_is | input | 1 | Instruction-space state bit |
| lk_lpid | input | 8 | Lookup partition ID |
| lk_pid | input | 14 | Lookup process ID |
| lk_ea | input | 64 | Effective address |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_multi | output | 1 | More than one entry matched |
| lk_ra | output | 42 | Real address |

## Verification
For every page size, the bench probes the address one bit above and one bit below the page boundary. The first must miss and the second must hit, which pins down each size's compare width. Each key field is flipped on its own, and the address-space source is swapped between fetch and data access, to show that every field takes part in the match. Every illegal size code and a misaligned frame are written over live entries to tell a refused write apart from an accepted one. An overlapping 4 KB and 1 GB pair separates a single hit from a multi-hit. A long mixed run of writes and lookups then compares every cycle against a behavioural model.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   // smallest page offset in address bits (4 KB)
   localparam int MIN_OFF = 12;

   // page-size codes; the offset width is 10 + 2*code address bits
   typedef enum logic [3:0] {
      SZ_4K  = 4'b0001,
      SZ_64K = 4'b0011,
      SZ_1M  = 4'b0101,
      SZ_16M = 4'b0111,
      SZ_1G  = 4'b1010
   } pg_size_e;

   // offset bits beyond MIN_OFF for the largest supported page
   localparam int MAX_EXTRA = 18;

endpackage

// File: rtl/xlate_size_dec.sv
module xlate_size_dec
   import xlate_pkg::*;
#(
   parameter bit ALLOW_1G = 1'b1
)(
   input  logic [3:0] code,
   output logic       supported,
   output logic [5:0] extra
);

   logic small_ok;

   always_comb begin
      small_ok = (code == SZ_4K) || (code == SZ_64K) ||
                 (code == SZ_1M) || (code == SZ_16M);
   end

   generate
      if (ALLOW_1G) begin : g_with_giant
         assign supported = small_ok || (code == SZ_1G);
      end else begin : g_no_giant
         assign supported = small_ok;
      end
   endgenerate

   // page offset beyond 4 KB: (10 + 2*code) - 12
   assign extra = supported ? ({1'b0, code, 1'b0} - 6'd2) : 6'd0;

endmodule

// File: rtl/xlate_entry.sv
module xlate_entry
   import xlate_pkg::*;
#(
   parameter int TAG_W    = 24,
   parameter int EPN_W    = 52,
   parameter int RPN_W    = 30,
   parameter bit ALLOW_1G = 1'b1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             wr_sel,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [EPN_W-1:0] wr_epn,
   input  logic [3:0]       wr_size,
   input  logic [RPN_W-1:0] wr_rpn,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [EPN_W-1:0] lk_epn,
   output logic             match,
   output logic [RPN_W-1:0] rpn,
   output logic [RPN_W-1:0] low_mask
);

   logic             v_q;
   logic [TAG_W-1:0] tag_q;
   logic [EPN_W-1:0] epn_q;
   logic [3:0]       size_q;
   logic [RPN_W-1:0] rpn_q;

   logic             size_sup;
   logic [5:0]       extra;
   logic [EPN_W-1:0] cmp_mask;
   logic             epn_eq;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         v_q <= 1'b0;
      end else if (wr_sel) begin
         v_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_sel && !clr) begin
         tag_q  <= wr_tag;
         epn_q  <= wr_epn;
         size_q <= wr_size;
         rpn_q  <= wr_rpn;
      end
   end

   xlate_size_dec #(
      .ALLOW_1G(ALLOW_1G)
   ) u_dec (
      .code     (size_q),
      .supported(size_sup),
      .extra    (extra)
   );

   always_comb begin
      for (int i = 0; i < EPN_W; i++) begin
         cmp_mask[i] = (i >= int'(extra));
      end
      for (int i = 0; i < RPN_W; i++) begin
         low_mask[i] = (i < int'(extra));
      end
   end

   assign epn_eq = (((epn_q ^ lk_epn) & cmp_mask) == '0);
   assign match  = v_q && size_sup && (tag_q == lk_tag) && epn_eq;
   assign rpn    = rpn_q;

   // an accepted write makes the entry live with the written key
   p_write_lands_r11: assert property (@(posedge clk) disable iff (rst)
      (wr_sel && !clr) |=> (v_q && tag_q == $past(wr_tag) && rpn_q == $past(wr_rpn)));

   // a clear leaves nothing that can match
   p_clear_empties_r10: assert property (@(posedge clk) disable iff (rst)
      clr |=> !match);

endmodule

// File: rtl/xlate_sel.sv
module xlate_sel
   import xlate_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int RPN_W   = 30,
   parameter int RA_W    = 42
)(
   input  logic                            clk,
   input  logic                            rst,
   input  logic [ENTRIES-1:0]              match,
   input  logic [ENTRIES-1:0][RPN_W-1:0]   rpn,
   input  logic [ENTRIES-1:0][RPN_W-1:0]   low_mask,
   input  logic [RA_W-1:0]                 ea_low,
   output logic                            hit,
   output logic                            multi,
   output logic [RA_W-1:0]                 ra
);

   logic [ENTRIES:0]            seen;
   logic [ENTRIES:0]            dup;
   logic [ENTRIES:0][RPN_W-1:0] rpn_acc;
   logic [ENTRIES:0][RPN_W-1:0] msk_acc;
   logic [RPN_W-1:0]            frame_hi;

   assign seen[0]    = 1'b0;
   assign dup[0]     = 1'b0;
   assign rpn_acc[0] = '0;
   assign msk_acc[0] = '0;

   // running chain: collision flag, AND-OR of frames and masks
   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_chain
         assign seen[g+1]    = seen[g] | match[g];
         assign dup[g+1]     = dup[g] | (seen[g] & match[g]);
         assign rpn_acc[g+1] = rpn_acc[g] | (rpn[g] & {RPN_W{match[g]}});
         assign msk_acc[g+1] = msk_acc[g] | (low_mask[g] & {RPN_W{match[g]}});
      end
   endgenerate

   assign multi = dup[ENTRIES];
   assign hit   = seen[ENTRIES] & ~dup[ENTRIES];

   assign frame_hi = (rpn_acc[ENTRIES] & ~msk_acc[ENTRIES]) |
                     (ea_low[RA_W-1:MIN_OFF] & msk_acc[ENTRIES]);

   assign ra = hit ? {frame_hi, ea_low[MIN_OFF-1:0]} : '0;

   p_single_source_r8: assert property (@(posedge clk) disable iff (rst)
      hit |-> ($countones(match) == 1));

   p_collision_seen_r8: assert property (@(posedge clk) disable iff (rst)
      multi |-> ($countones(match) > 1 && ra == '0));

   p_no_match_r7: assert property (@(posedge clk) disable iff (rst)
      (match == '0) |-> (!hit && !multi));

endmodule

// File: rtl/mmu_xlate_cam.sv
module mmu_xlate_cam
   import xlate_pkg::*;
#(
   parameter int ENTRIES  = 16,
   parameter int EA_W     = 64,
   parameter int RA_W     = 42,
   parameter int LPID_W   = 8,
   parameter int PID_W    = 14,
   parameter bit ALLOW_1G = 1'b1,
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int EPN_W   = EA_W - MIN_OFF,
   localparam int RPN_W   = RA_W - MIN_OFF
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              inval_all,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_gs,
   input  logic              wr_as,
   input  logic [LPID_W-1:0] wr_lpid,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic [EPN_W-1:0]  wr_epn,
   input  logic [3:0]        wr_size,
   input  logic [RPN_W-1:0]  wr_rpn,
   output logic              wr_err,
   input  logic              lk_ifetch,
   input  logic              lk_gs,
   input  logic              lk_ds,
   input  logic              lk_is,
   input  logic [LPID_W-1:0] lk_lpid,
   input  logic [PID_W-1:0]  lk_pid,
   input  logic [EA_W-1:0]   lk_ea,
   output logic              lk_hit,
   output logic              lk_multi,
   output logic [RA_W-1:0]   lk_ra
);

   localparam int TAG_W = 2 + LPID_W + PID_W;

   // elaboration-time parameter checks
   generate
      if (ENTRIES < 2) begin : g_chk_entries
         $error("mmu_xlate_cam: ENTRIES must be at least 2");
      end
      if (RPN_W < MAX_EXTRA || EPN_W < MAX_EXTRA) begin : g_chk_widths
         $error("mmu_xlate_cam: address widths too narrow for the largest page");
      end
      if (RA_W > EA_W) begin : g_chk_ra
         $error("mmu_xlate_cam: real address wider than effective address");
      end
   endgenerate

   // lookup key
   logic             as_sel;
   logic [TAG_W-1:0] lk_tag;
   logic [TAG_W-1:0] wr_tag;
   logic [EPN_W-1:0] lk_epn;

   assign as_sel = lk_ifetch ? lk_is : lk_ds;
   assign lk_tag = {lk_gs, as_sel, lk_lpid, lk_pid};
   assign wr_tag = {wr_gs, wr_as, wr_lpid, wr_pid};
   assign lk_epn = lk_ea[EA_W-1:MIN_OFF];

   // write screening
   logic             wr_sup;
   logic [5:0]       wr_extra;
   logic [RPN_W-1:0] wr_low;
   logic             wr_misalign;
   logic             wr_bad;
   logic             wr_accept;
   logic             err_q;

   xlate_size_dec #(
      .ALLOW_1G(ALLOW_1G)
   ) u_wr_dec (
      .code     (wr_size),
      .supported(wr_sup),
      .extra    (wr_extra)
   );

   always_comb begin
      for (int i = 0; i < RPN_W; i++) begin
         wr_low[i] = (i < int'(wr_extra));
      end
   end

   assign wr_misalign = |(wr_rpn & wr_low);
   assign wr_bad      = wr_en && !inval_all && (!wr_sup || wr_misalign);
   assign wr_accept   = wr_en && !inval_all && wr_sup && !wr_misalign;

   always_ff @(posedge clk) begin
      if (rst) begin
         err_q <= 1'b0;
      end else begin
         err_q <= wr_bad;
      end
   end

   assign wr_err = err_q;

   // entry array
   logic [ENTRIES-1:0]            match;
   logic [ENTRIES-1:0][RPN_W-1:0] e_rpn;
   logic [ENTRIES-1:0][RPN_W-1:0] e_low;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         logic sel;
         assign sel = wr_accept && (wr_idx == IDX_W'(g));

         xlate_entry #(
            .TAG_W   (TAG_W),
            .EPN_W   (EPN_W),
            .RPN_W   (RPN_W),
            .ALLOW_1G(ALLOW_1G)
         ) u_entry (
            .clk     (clk),
            .rst     (rst),
            .clr     (inval_all),
            .wr_sel  (sel),
            .wr_tag  (wr_tag),
            .wr_epn  (wr_epn),
            .wr_size (wr_size),
            .wr_rpn  (wr_rpn),
            .lk_tag  (lk_tag),
            .lk_epn  (lk_epn),
            .match   (match[g]),
            .rpn     (e_rpn[g]),
            .low_mask(e_low[g])
         );
      end
   endgenerate

   xlate_sel #(
      .ENTRIES(ENTRIES),
      .RPN_W  (RPN_W),
      .RA_W   (RA_W)
   ) u_sel (
      .clk     (clk),
      .rst     (rst),
      .match   (match),
      .rpn     (e_rpn),
      .low_mask(e_low),
      .ea_low  (lk_ea[RA_W-1:0]),
      .hit     (lk_hit),
      .multi   (lk_multi),
      .ra      (lk_ra)
   );

   p_bad_code_flag_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !inval_all && !wr_sup) |=> wr_err);

   p_bad_frame_flag_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !inval_all && wr_sup && wr_misalign) |=> wr_err);

   p_good_write_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      wr_accept |=> !wr_err);

   p_flush_wins_r10: assert property (@(posedge clk) disable iff (rst)
      inval_all |=> (!wr_err && !lk_hit && !lk_multi));

   p_miss_zero_r7: assert property (@(posedge clk) disable iff (rst)
      !lk_hit |-> (lk_ra == '0));

   p_hit_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(lk_hit && lk_multi));

endmodule

// File: tb/mmu_xlate_cam_test.sv
module mmu_xlate_cam_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        inval_all;
   logic        wr_en;
   logic [3:0]  wr_idx;
   logic        wr_gs, wr_as;
   logic [7:0]  wr_lpid;
   logic [13:0] wr_pid;
   logic [51:0] wr_epn;
   logic [3:0]  wr_size;
   logic [29:0] wr_rpn;
   logic        wr_err;
   logic        lk_ifetch, lk_gs, lk_ds, lk_is;
   logic [7:0]  lk_lpid;
   logic [13:0] lk_pid;
   logic [63:0] lk_ea;
   logic        lk_hit, lk_multi;
   logic [41:0] lk_ra;

   int vectors = 0;
   int miscompares = 0;

   always #4 clk = ~clk;

   mmu_xlate_cam uut (
      .clk(clk), .rst(rst), .inval_all(inval_all),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_gs(wr_gs), .wr_as(wr_as),
      .wr_lpid(wr_lpid), .wr_pid(wr_pid), .wr_epn(wr_epn),
      .wr_size(wr_size), .wr_rpn(wr_rpn), .wr_err(wr_err),
      .lk_ifetch(lk_ifetch), .lk_gs(lk_gs), .lk_ds(lk_ds), .lk_is(lk_is),
      .lk_lpid(lk_lpid), .lk_pid(lk_pid), .lk_ea(lk_ea),
      .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_ra(lk_ra)
   );

   // ---------------- behavioural reference ----------------
   bit          m_v   [16];
   bit          m_gs  [16];
   bit          m_as  [16];
   logic [7:0]  m_lpid[16];
   logic [13:0] m_pid [16];
   logic [51:0] m_epn [16];
   int          m_off [16];
   logic [29:0] m_rpn [16];
   bit          exp_err;

   function automatic bit code_legal(input logic [3:0] c);
      return (c == 4'd1) || (c == 4'd3) || (c == 4'd5) || (c == 4'd7) || (c == 4'd10);
   endfunction

   function automatic int offset_of(input logic [3:0] c);
      return 10 + 2 * int'(c);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
         exp_err = 1'b0;
      end else begin
         exp_err = 1'b0;
         if (inval_all) begin
            for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
         end else if (wr_en) begin
            if (!code_legal(wr_size)) begin
               exp_err = 1'b1;
            end else if ((wr_rpn % (30'd1 << (offset_of(wr_size) - 12))) != 0) begin
               exp_err = 1'b1;
            end else begin
               m_v[wr_idx]    = 1'b1;
               m_gs[wr_idx]   = wr_gs;
               m_as[wr_idx]   = wr_as;
               m_lpid[wr_idx] = wr_lpid;
               m_pid[wr_idx]  = wr_pid;
               m_epn[wr_idx]  = wr_epn;
               m_off[wr_idx]  = offset_of(wr_size);
               m_rpn[wr_idx]  = wr_rpn;
            end
         end
      end
   end

   task automatic model_lookup(output bit eh, output bit em, output logic [41:0] er);
      int          cnt;
      int          k;
      bit          asb;
      logic [63:0] page;
      logic [63:0] frame;
      cnt = 0;
      k = 0;
      asb = lk_ifetch ? lk_is : lk_ds;
      for (int i = 0; i < 16; i++) begin
         page = {m_epn[i], 12'h000};
         if (m_v[i] && m_gs[i] == lk_gs && m_as[i] == asb &&
             m_lpid[i] == lk_lpid && m_pid[i] == lk_pid &&
             (lk_ea >> m_off[i]) == (page >> m_off[i])) begin
            cnt++;
            k = i;
         end
      end
      eh = (cnt == 1);
      em = (cnt > 1);
      er = '0;
      if (eh) begin
         frame = {22'd0, m_rpn[k], 12'h000};
         frame = (frame >> m_off[k]) << m_off[k];
         er = frame[41:0] | (lk_ea[41:0] & ((42'd1 << m_off[k]) - 42'd1));
      end
   endtask

   // compare the current cycle, then move to the next falling edge
   task automatic cyc(input string tag);
      bit          eh, em;
      logic [41:0] er;
      #1;
      model_lookup(eh, em, er);
      vectors++;
      if (lk_hit !== eh || lk_multi !== em || lk_ra !== er || wr_err !== exp_err) begin
         miscompares++;
         $display("FAIL %s: hit=%0b multi=%0b ra=%h err=%0b expected hit=%0b multi=%0b ra=%h err=%0b",
                  tag, lk_hit, lk_multi, lk_ra, wr_err, eh, em, er, exp_err);
      end
      @(negedge clk);
   endtask

   // ---------------- stimulus helpers ----------------
   bit          k_gs  [5];
   bit          k_as  [5];
   logic [7:0]  k_lpid[5];
   logic [13:0] k_pid [5];
   logic [51:0] k_epn [5];
   logic [29:0] k_rpn [5];
   logic [3:0]  k_code[5];

   function automatic logic [63:0] rand64();
      return {$urandom(), $urandom()};
   endfunction

   task automatic aim(input int s, input int off);
      logic [63:0] ea;
      ea = {k_epn[s], 12'h000};
      ea = ((ea >> off) << off) | (rand64() & ((64'd1 << off) - 64'd1));
      lk_ifetch = 1'b0;
      lk_gs = k_gs[s];
      lk_ds = k_as[s];
      lk_is = ~k_as[s];
      lk_lpid = k_lpid[s];
      lk_pid = k_pid[s];
      lk_ea = ea;
   endtask

   task automatic put(input int idx, input bit gs, input bit as_b, input logic [7:0] lp,
                      input logic [13:0] pd, input logic [51:0] epn,
                      input logic [3:0] c, input logic [29:0] rpn);
      wr_en = 1'b1;
      wr_idx = 4'(idx);
      wr_gs = gs;
      wr_as = as_b;
      wr_lpid = lp;
      wr_pid = pd;
      wr_epn = epn;
      wr_size = c;
      wr_rpn = rpn;
   endtask

   // ---------------- main sequence ----------------
   initial begin
      logic [3:0]  codes[5];
      logic [63:0] base;
      int          off;
      codes = '{4'd1, 4'd3, 4'd5, 4'd7, 4'd10};

      rst = 1'b1;
      inval_all = 1'b0;
      wr_en = 1'b0;
      wr_idx = '0; wr_gs = 0; wr_as = 0; wr_lpid = '0; wr_pid = '0;
      wr_epn = '0; wr_size = 4'd1; wr_rpn = '0;
      lk_ifetch = 0; lk_gs = 0; lk_ds = 0; lk_is = 0;
      lk_lpid = '0; lk_pid = '0; lk_ea = '0;
      @(negedge clk);
      cyc("R9");
      cyc("R9");
      rst = 1'b0;
      cyc("R9");

      // one entry per size, with boundary and key-field probes
      for (int s = 0; s < 5; s++) begin
         k_code[s] = codes[s];
         off = offset_of(codes[s]);
         k_gs[s] = 1'($urandom());
         k_as[s] = 1'($urandom());
         k_lpid[s] = 8'($urandom());
         k_pid[s] = 14'($urandom());
         k_epn[s] = 52'(rand64());
         k_rpn[s] = 30'($urandom());
         k_rpn[s] = (k_rpn[s] >> (off - 12)) << (off - 12);
         put(s + 1, k_gs[s], k_as[s], k_lpid[s], k_pid[s], k_epn[s], k_code[s], k_rpn[s]);
         aim(s, off);
         cyc("R12");
         wr_en = 1'b0;
         cyc("R4");
         base = lk_ea;
         lk_ea = base ^ (64'd1 << off);
         cyc("R3");
         lk_ea = base ^ (64'd1 << (off - 1));
         cyc("R3");
         lk_ea = base ^ 64'h8000_0000_0000_0000;
         cyc("R1");
         lk_ea = base;
         lk_gs = ~lk_gs;
         cyc("R1");
         lk_gs = ~lk_gs;
         lk_lpid = lk_lpid ^ 8'h10;
         cyc("R1");
         lk_lpid = k_lpid[s];
         lk_pid = lk_pid ^ 14'h0201;
         cyc("R1");
         lk_pid = k_pid[s];
         lk_ifetch = 1'b1;
         lk_is = k_as[s];
         lk_ds = ~k_as[s];
         cyc("R2");
         lk_is = ~k_as[s];
         lk_ds = k_as[s];
         cyc("R2");
      end

      // every illegal size code over the live 4 KB entry at index 1
      for (int c = 0; c < 16; c++) begin
         if (!code_legal(4'(c))) begin
            put(1, k_gs[0], k_as[0], k_lpid[0], k_pid[0], k_epn[0] ^ 52'h1, 4'(c), 30'd0);
            aim(0, 12);
            cyc("R5");
            wr_en = 1'b0;
            cyc("R5");
         end
      end

      // misaligned 64 KB frame over index 2, then an odd 4 KB frame accepted
      put(2, k_gs[1], k_as[1], k_lpid[1], k_pid[1], k_epn[1], 4'd3, k_rpn[1] | 30'd1);
      aim(1, 16);
      cyc("R6");
      wr_en = 1'b0;
      cyc("R6");
      put(6, 1'b0, 1'b0, 8'h33, 14'h0123, 52'h12345, 4'd1, 30'h0000_0fff);
      cyc("R6");
      wr_en = 1'b0;
      lk_ifetch = 0; lk_gs = 0; lk_ds = 0; lk_lpid = 8'h33; lk_pid = 14'h0123;
      lk_ea = {52'h12345, 12'hABC};
      cyc("R6");

      // rewrite index 1 with a different page
      put(1, k_gs[0], k_as[0], k_lpid[0], k_pid[0], k_epn[0] ^ 52'h8_0000, 4'd1, 30'h1357);
      aim(0, 12);
      cyc("R11");
      wr_en = 1'b0;
      cyc("R11");
      lk_ea = {k_epn[0] ^ 52'h8_0000, 12'h321};
      cyc("R11");

      // overlapping 4 KB and 1 GB entries with the same key
      put(8, 1'b1, 1'b0, 8'h5A, 14'h2AAA, 52'hABCDE_1234_5, 4'd1, 30'h0002_1001);
      cyc("R8");
      put(9, 1'b1, 1'b0, 8'h5A, 14'h2AAA, 52'hABCDE_1200_0, 4'd10, 30'h3004_0000);
      cyc("R8");
      wr_en = 1'b0;
      lk_ifetch = 0; lk_gs = 1; lk_ds = 0; lk_lpid = 8'h5A; lk_pid = 14'h2AAA;
      lk_ea = {52'hABCDE_1234_5, 12'h777};
      cyc("R8");
      lk_ea = {52'hABCDE_1234_6, 12'h777};
      cyc("R8");

      // flush, and flush against a concurrent write
      inval_all = 1'b1;
      cyc("R10");
      inval_all = 1'b0;
      cyc("R10");
      aim(2, 20);
      cyc("R10");
      put(4, k_gs[2], k_as[2], k_lpid[2], k_pid[2], k_epn[2], k_code[2], k_rpn[2]);
      inval_all = 1'b1;
      cyc("R10");
      put(5, 1'b0, 1'b0, 8'h0, 14'h0, 52'h0, 4'd2, 30'h0);
      cyc("R10");
      inval_all = 1'b0;
      wr_en = 1'b0;
      cyc("R10");
      cyc("R10");

      // reset in mid-run clears the array
      put(3, k_gs[3], k_as[3], k_lpid[3], k_pid[3], k_epn[3], k_code[3], k_rpn[3]);
      cyc("R9");
      wr_en = 1'b0;
      aim(3, 24);
      cyc("R9");
      rst = 1'b1;
      cyc("R9");
      rst = 1'b0;
      cyc("R9");

      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         int pick;
         logic [3:0] c;
         pick = int'($urandom() % 16);
         if (($urandom() % 3) == 0) begin
            c = (($urandom() % 8) == 0) ? 4'($urandom()) : codes[$urandom() % 5];
            put(pick, 1'($urandom()), 1'($urandom()), 8'($urandom() % 4),
                14'($urandom() % 4), 52'(rand64() % 64), c,
                (($urandom() % 6) == 0) ? 30'($urandom()) :
                   ((30'($urandom()) >> 18) << 18));
         end else begin
            wr_en = 1'b0;
         end
         inval_all = (($urandom() % 97) == 0);
         if (m_v[pick]) begin
            lk_ea = {m_epn[pick], 12'h000};
            lk_ea = ((lk_ea >> m_off[pick]) << m_off[pick]) |
                    (rand64() & ((64'd1 << m_off[pick]) - 64'd1));
            lk_gs = m_gs[pick];
            lk_ifetch = 1'($urandom());
            lk_ds = m_as[pick];
            lk_is = m_as[pick];
            lk_lpid = m_lpid[pick];
            lk_pid = m_pid[pick];
         end else begin
            lk_ea = rand64() % 64'h10_0000_0000;
            lk_gs = 1'($urandom());
            lk_ds = 1'($urandom());
            lk_is = 1'($urandom());
            lk_lpid = 8'($urandom() % 4);
            lk_pid = 14'($urandom() % 4);
         end
         cyc("R4");
      end
      wr_en = 1'b0;
      inval_all = 1'b0;
      cyc("R7");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule